// File: doc/BRIEF.md
# Linked-List Descriptor DMA Channel

This block is one bus-master DMA channel that works through a chain of transfer descriptors kept in memory. Software writes the address of the first descriptor into a pointer register and sets enable and start together in the control/status register. The channel then reads each descriptor as four 32-bit words over a simple memory-read port. It moves the described number of bytes between a system-memory address and a device-side address over a request/acknowledge move port. It then follows the descriptor's link word until it meets a link that carries the end-of-chain flag.

A completed chain sets a sticky transfer-done flag. Each finished descriptor sets a sticky descriptor-done flag. Both are cleared by writing one to them. An interrupt is raised only while transfer-done and the interrupt enable are both set. An abort stops the channel at once, drops enable and sets no done flag, so software learns that the abort is over by polling enable and busy.

Top module: `chain_dma`

## Requirements
- R1: A descriptor is read as four words from the descriptor address plus 0, 4, 8 and 12, in this order: system-memory address, device address, byte count, link word. Each fetch address has its two low bits zero.
- R2: Each accepted move handshake transfers min(4, remaining) bytes at the current memory and device addresses, and both addresses then advance by that amount. Requests and addresses hold steady until they are acknowledged.
- R3: In chain mode (mode bit 0 = 1), the link word with its two low bits cleared becomes the next descriptor address, unless link bit 1 (end-of-chain) is set. In that case the chain ends: transfer-done (CSR bit 3) sets, busy (CSR bit 5) clears, and the pointer register (offset 2) holds the last descriptor's address.
- R4: With chain mode off, only the first descriptor is processed, and the chain then ends as in R3.
- R5: Writing one to CSR bit 3 or bit 4 clears that flag. Writing zero leaves it set.
- R6: Descriptor-done (CSR bit 4) sets when any descriptor finishes.
- R7: A CSR write with abort (bit 2) set, or with enable (bit 0) clear, while busy stops the channel on the next cycle. Enable clears, no transfer-done is set, no further requests are made, and the interrupt does not rise.
- R8: irq_o is high exactly when transfer-done and the interrupt-enable (mode bit 1) are both set.
- R9: Start (CSR bit 1, written together with enable) has no effect while busy. Writes to offsets 2 to 5 are ignored while busy.
- R10: The byte-count register (offset 5) counts down as bytes move, and reads zero when a chain ends. The memory address register (offset 3) reads the last descriptor's address plus its count.
- R11: Starting with end-of-chain set in the pointer register finishes at once: transfer-done is set on the next cycle and no descriptor is fetched.
- R12: A descriptor with a zero byte count makes no move request, and the chain proceeds to its link.
- R13: After reset all registers read zero, irq_o is low and neither port requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset (0 CSR, 1 mode, 2 pointer, 3 mem addr, 4 dev addr, 5 count) |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data for reg_addr_i |
| irq_o | output | 1 | Done interrupt |
| fetch_req_o | output | 1 | Descriptor word read request |
| fetch_addr_o | output | DW | Descriptor word address |
| fetch_ack_i | input | 1 | Read accepted, data valid |
| fetch_data_i | input | DW | Descriptor word |
| move_req_o | output | 1 | Chunk move request |
| move_mem_addr_o | output | DW | System-memory address of the chunk |
| move_dev_addr_o | output | DW | Device address of the chunk |
| move_bytes_o | output | BW | Bytes in this chunk |
| move_ack_i | input | 1 | Chunk moved |

## Verification
The bench builds chains whose link words carry stray low bits, mixes in zero-count descriptors and counts that are not multiples of four, and compares every move against a list computed by walking the chain. A design that kept the stray bits, skipped a zero-count descriptor wrongly or overran a short tail would produce misaddressed or oversized moves. Directed cases cover an abort held mid-transfer, a restart and pointer write issued during a run, a pointer that already carries end-of-chain, and chain mode off. These catch a design that raises done on abort, restarts its fetch, fetches anything from a terminal pointer, or follows the link when told not to. The write-one-to-clear test writes zero to one flag and one to the other, which exposes a design that clears both.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
    localparam logic [2:0] A_CSR   = 3'd0;
    localparam logic [2:0] A_MODE  = 3'd1;
    localparam logic [2:0] A_DPTR  = 3'd2;
    localparam logic [2:0] A_MADDR = 3'd3;
    localparam logic [2:0] A_DADDR = 3'd4;
    localparam logic [2:0] A_COUNT = 3'd5;

    localparam int B_EN    = 0;
    localparam int B_GO    = 1;
    localparam int B_ABORT = 2;
    localparam int B_XDONE = 3;
    localparam int B_DDONE = 4;

    localparam int M_CHAIN = 0;
    localparam int M_IRQEN = 1;

    localparam int LAST_BIT = 1;

    typedef enum logic [1:0] {W_IDLE, W_FETCH, W_MOVE} wstate_e;
endpackage

// File: rtl/chain_dma_walker.sv
module chain_dma_walker
    import chain_dma_pkg::*;
#(
    parameter int DW         = 32,
    parameter int BEAT_BYTES = 4,
    parameter int BW         = $clog2(BEAT_BYTES) + 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic          abort_i,
    input  logic          chain_mode_i,
    input  logic          sw_we_i,
    input  logic [2:0]    sw_sel_i,
    input  logic [DW-1:0] sw_wdata_i,
    output logic          fetch_req_o,
    output logic [DW-1:0] fetch_addr_o,
    input  logic          fetch_ack_i,
    input  logic [DW-1:0] fetch_data_i,
    output logic          move_req_o,
    output logic [DW-1:0] move_mem_addr_o,
    output logic [DW-1:0] move_dev_addr_o,
    output logic [BW-1:0] move_bytes_o,
    input  logic          move_ack_i,
    output logic          busy_o,
    output logic          fin_o,
    output logic          desc_fin_o,
    output logic [DW-1:0] dptr_o,
    output logic [DW-1:0] maddr_o,
    output logic [DW-1:0] daddr_o,
    output logic [DW-1:0] count_o
);
    typedef struct packed {
        wstate_e       st;
        logic [1:0]    widx;
        logic [DW-1:0] dptr;
        logic [DW-1:0] maddr;
        logic [DW-1:0] daddr;
        logic [DW-1:0] count;
        logic [DW-1:0] link;
    } walk_t;

    walk_t         q, d;
    logic [BW-1:0] beat_w;
    logic [DW-1:0] step_w;
    logic [DW-1:0] link_w;
    logic          adv;

    function automatic logic [DW-1:0] align(input logic [DW-1:0] a);
        return {a[DW-1:2], 2'b00};
    endfunction

    always_comb begin
        beat_w     = (q.count < DW'(BEAT_BYTES)) ? q.count[BW-1:0] : BW'(BEAT_BYTES);
        step_w     = DW'(beat_w);
        link_w     = (q.st == W_FETCH) ? fetch_data_i : q.link;
        d          = q;
        adv        = 1'b0;
        fin_o      = 1'b0;
        desc_fin_o = 1'b0;
        case (q.st)
            W_IDLE: begin
                if (sw_we_i) begin
                    case (sw_sel_i)
                        A_DPTR:  d.dptr  = sw_wdata_i;
                        A_MADDR: d.maddr = sw_wdata_i;
                        A_DADDR: d.daddr = sw_wdata_i;
                        A_COUNT: d.count = sw_wdata_i;
                        default: ;
                    endcase
                end
                if (start_i) begin
                    if (q.dptr[LAST_BIT]) begin
                        fin_o = 1'b1;
                    end else begin
                        d.st   = W_FETCH;
                        d.widx = 2'd0;
                        d.dptr = align(q.dptr);
                    end
                end
            end
            W_FETCH: begin
                if (fetch_ack_i) begin
                    case (q.widx)
                        2'd0:    d.maddr = fetch_data_i;
                        2'd1:    d.daddr = fetch_data_i;
                        2'd2:    d.count = fetch_data_i;
                        default: d.link  = fetch_data_i;
                    endcase
                    d.widx = q.widx + 2'd1;
                    if (q.widx == 2'd3) begin
                        if (q.count == '0) adv = 1'b1;
                        else               d.st = W_MOVE;
                    end
                end
            end
            W_MOVE: begin
                if (move_ack_i) begin
                    d.maddr = q.maddr + step_w;
                    d.daddr = q.daddr + step_w;
                    d.count = q.count - step_w;
                    if (q.count == step_w) adv = 1'b1;
                end
            end
            default: d.st = W_IDLE;
        endcase
        if (adv) begin
            desc_fin_o = 1'b1;
            if (!chain_mode_i || link_w[LAST_BIT]) begin
                fin_o = 1'b1;
                d.st  = W_IDLE;
            end else begin
                d.dptr = align(link_w);
                d.widx = 2'd0;
                d.st   = W_FETCH;
            end
        end
        if (abort_i && q.st != W_IDLE) begin
            d.st       = W_IDLE;
            fin_o      = 1'b0;
            desc_fin_o = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign fetch_req_o     = (q.st == W_FETCH);
    assign fetch_addr_o    = q.dptr + DW'({q.widx, 2'b00});
    assign move_req_o      = (q.st == W_MOVE);
    assign move_mem_addr_o = q.maddr;
    assign move_dev_addr_o = q.daddr;
    assign move_bytes_o    = beat_w;
    assign busy_o          = (q.st != W_IDLE);
    assign dptr_o          = q.dptr;
    assign maddr_o         = q.maddr;
    assign daddr_o         = q.daddr;
    assign count_o         = q.count;
endmodule

// File: rtl/chain_dma_regs.sv
module chain_dma_regs
    import chain_dma_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [2:0]    addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    input  logic          busy_i,
    input  logic          fin_i,
    input  logic          desc_fin_i,
    input  logic [DW-1:0] dptr_i,
    input  logic [DW-1:0] maddr_i,
    input  logic [DW-1:0] daddr_i,
    input  logic [DW-1:0] count_i,
    output logic          start_o,
    output logic          abort_o,
    output logic          sw_we_o,
    output logic          chain_mode_o,
    output logic          xdone_o,
    output logic          irq_o
);
    typedef struct packed {
        logic en;
        logic xdone;
        logic ddone;
        logic chain;
        logic irq_en;
    } ctl_t;

    ctl_t q, d;
    logic csr_wr, mode_wr;

    always_comb begin
        csr_wr  = we_i && (addr_i == A_CSR);
        mode_wr = we_i && (addr_i == A_MODE);
        start_o = csr_wr && wdata_i[B_EN] && wdata_i[B_GO] && !wdata_i[B_ABORT] && !busy_i;
        abort_o = csr_wr && (wdata_i[B_ABORT] || !wdata_i[B_EN]);
        sw_we_o = we_i && !busy_i && (addr_i >= A_DPTR) && (addr_i <= A_COUNT);
        d = q;
        if (csr_wr) begin
            d.en = wdata_i[B_EN] && !wdata_i[B_ABORT];
            if (wdata_i[B_XDONE]) d.xdone = 1'b0;
            if (wdata_i[B_DDONE]) d.ddone = 1'b0;
        end
        if (fin_i)      d.xdone = 1'b1;
        if (desc_fin_i) d.ddone = 1'b1;
        if (mode_wr) begin
            d.chain  = wdata_i[M_CHAIN];
            d.irq_en = wdata_i[M_IRQEN];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    always_comb begin
        case (addr_i)
            A_CSR:   rdata_o = DW'({busy_i, q.ddone, q.xdone, 2'b00, q.en});
            A_MODE:  rdata_o = DW'({q.irq_en, q.chain});
            A_DPTR:  rdata_o = dptr_i;
            A_MADDR: rdata_o = maddr_i;
            A_DADDR: rdata_o = daddr_i;
            A_COUNT: rdata_o = count_i;
            default: rdata_o = '0;
        endcase
    end

    assign chain_mode_o = q.chain;
    assign xdone_o      = q.xdone;
    assign irq_o        = q.xdone && q.irq_en;
endmodule

// File: rtl/chain_dma.sv
module chain_dma
    import chain_dma_pkg::*;
#(
    parameter int  DW         = 32,
    parameter int  BEAT_BYTES = 4,
    localparam int BW         = $clog2(BEAT_BYTES) + 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          reg_we_i,
    input  logic [2:0]    reg_addr_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    output logic          irq_o,
    output logic          fetch_req_o,
    output logic [DW-1:0] fetch_addr_o,
    input  logic          fetch_ack_i,
    input  logic [DW-1:0] fetch_data_i,
    output logic          move_req_o,
    output logic [DW-1:0] move_mem_addr_o,
    output logic [DW-1:0] move_dev_addr_o,
    output logic [BW-1:0] move_bytes_o,
    input  logic          move_ack_i
);
    logic          start_w, abort_w, sw_we_w, chain_w, busy_w, fin_w, dfin_w, xdone_w;
    logic [DW-1:0] dptr_w, maddr_w, daddr_w, count_w;

    chain_dma_regs #(.DW(DW)) regs_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
        .busy_i(busy_w), .fin_i(fin_w), .desc_fin_i(dfin_w),
        .dptr_i(dptr_w), .maddr_i(maddr_w), .daddr_i(daddr_w), .count_i(count_w),
        .start_o(start_w), .abort_o(abort_w), .sw_we_o(sw_we_w),
        .chain_mode_o(chain_w), .xdone_o(xdone_w), .irq_o(irq_o)
    );

    chain_dma_walker #(.DW(DW), .BEAT_BYTES(BEAT_BYTES), .BW(BW)) walk_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .start_i(start_w), .abort_i(abort_w), .chain_mode_i(chain_w),
        .sw_we_i(sw_we_w), .sw_sel_i(reg_addr_i), .sw_wdata_i(reg_wdata_i),
        .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
        .fetch_ack_i(fetch_ack_i), .fetch_data_i(fetch_data_i),
        .move_req_o(move_req_o), .move_mem_addr_o(move_mem_addr_o),
        .move_dev_addr_o(move_dev_addr_o), .move_bytes_o(move_bytes_o),
        .move_ack_i(move_ack_i),
        .busy_o(busy_w), .fin_o(fin_w), .desc_fin_o(dfin_w),
        .dptr_o(dptr_w), .maddr_o(maddr_w), .daddr_o(daddr_w), .count_o(count_w)
    );
endmodule

// File: rtl/chain_dma_chk.sv
module chain_dma_chk #(
    parameter int DW         = 32,
    parameter int BEAT_BYTES = 4,
    parameter int BW         = $clog2(BEAT_BYTES) + 1
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          fetch_req_i,
    input logic          fetch_ack_i,
    input logic [DW-1:0] fetch_addr_i,
    input logic          move_req_i,
    input logic          move_ack_i,
    input logic [DW-1:0] move_mem_addr_i,
    input logic [DW-1:0] move_dev_addr_i,
    input logic [BW-1:0] move_bytes_i,
    input logic          abort_i,
    input logic          busy_i,
    input logic          xdone_i,
    input logic [DW-1:0] count_i
);
    p_fetch_aligned_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fetch_req_i |-> (fetch_addr_i[1:0] == 2'b00));

    p_fetch_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fetch_req_i && !fetch_ack_i && !abort_i) |=> (fetch_req_i && $stable(fetch_addr_i)));

    p_move_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (move_req_i && !move_ack_i && !abort_i)
        |=> (move_req_i && $stable(move_mem_addr_i) && $stable(move_dev_addr_i)));

    p_move_size_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        move_req_i |-> (move_bytes_i != '0 && move_bytes_i <= BW'(BEAT_BYTES)));

    p_one_port_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(fetch_req_i && move_req_i));

    p_abort_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (abort_i && busy_i) |=> (!busy_i && !$rose(xdone_i)));

    p_count_drained_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(busy_i) && !$past(abort_i)) |-> (count_i == '0));
endmodule

bind chain_dma chain_dma_chk #(.DW(DW), .BEAT_BYTES(BEAT_BYTES), .BW(BW)) chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .fetch_req_i(fetch_req_o), .fetch_ack_i(fetch_ack_i), .fetch_addr_i(fetch_addr_o),
    .move_req_i(move_req_o), .move_ack_i(move_ack_i),
    .move_mem_addr_i(move_mem_addr_o), .move_dev_addr_i(move_dev_addr_o),
    .move_bytes_i(move_bytes_o),
    .abort_i(abort_w), .busy_i(busy_w), .xdone_i(xdone_w), .count_i(count_w)
);

// File: tb/chain_dma_tb_top.sv
`timescale 1ns/1ps
module chain_dma_tb_top;
    import chain_dma_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        fetch_req, fetch_ack = 1'b0, move_req, move_ack = 1'b0;
    logic [31:0] fetch_addr, fetch_data = '0, mv_mem, mv_dev;
    logic [2:0]  mv_bytes;

    always #2.5 clk = ~clk;

    chain_dma dut_i (
        .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
        .fetch_req_o(fetch_req), .fetch_addr_o(fetch_addr), .fetch_ack_i(fetch_ack),
        .fetch_data_i(fetch_data), .move_req_o(move_req), .move_mem_addr_o(mv_mem),
        .move_dev_addr_o(mv_dev), .move_bytes_o(mv_bytes), .move_ack_i(move_ack)
    );

    logic [31:0] mem [0:63];
    int n_chk = 0, n_fail = 0;
    int mv_idx = 0, n_fetch = 0, exp_n = 0, exp_ndesc = 0, ack_pct = 60;
    bit hold = 1'b0, finished = 1'b0;
    logic [31:0] exp_m [0:511];
    logic [31:0] exp_d [0:511];
    logic [31:0] exp_b [0:511];
    logic [31:0] exp_last, exp_mar;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // memory and move responder
    initial begin
        forever begin
            @(negedge clk);
            fetch_ack = 1'b0;
            move_ack  = 1'b0;
            if (!hold && rst_n) begin
                if (fetch_req && ($urandom % 100) < ack_pct) begin
                    fetch_ack  = 1'b1;
                    fetch_data = mem[fetch_addr[7:2]];
                    n_fetch++;
                end
                if (move_req && ($urandom % 100) < ack_pct) begin
                    move_ack = 1'b1;
                    if (mv_idx < 512) begin
                        chk(mv_mem == exp_m[mv_idx], "R2 move mem addr", mv_mem, exp_m[mv_idx]);
                        chk(mv_dev == exp_d[mv_idx], "R2 move dev addr", mv_dev, exp_d[mv_idx]);
                        chk(32'(mv_bytes) == exp_b[mv_idx], "R2 move size", 32'(mv_bytes), exp_b[mv_idx]);
                    end
                    mv_idx++;
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.2;
        v = reg_rdata;
    endtask

    task automatic put_desc(input int slot, input logic [31:0] m, d, c, n);
        mem[slot*4+0] = m; mem[slot*4+1] = d; mem[slot*4+2] = c; mem[slot*4+3] = n;
    endtask

    // expected move list from walking the chain in bench memory
    task automatic build_exp(input logic [31:0] start, input bit chain);
        logic [31:0] a;
        exp_n = 0; exp_ndesc = 0; a = {start[31:2], 2'b00};
        exp_last = '0; exp_mar = '0;
        if (start[1]) return;
        for (int k = 0; k < 16; k++) begin
            logic [31:0] m, d, c, n, rem, off, b;
            m = mem[a[7:2]]; d = mem[a[7:2]+1]; c = mem[a[7:2]+2]; n = mem[a[7:2]+3];
            rem = c; off = 0;
            while (rem > 0) begin
                b = (rem < 4) ? rem : 32'd4;
                exp_m[exp_n] = m + off; exp_d[exp_n] = d + off; exp_b[exp_n] = b;
                exp_n++; rem -= b; off += b;
            end
            exp_ndesc++; exp_last = a; exp_mar = m + c;
            if (!chain || n[1]) break;
            a = {n[31:2], 2'b00};
        end
    endtask

    task automatic launch(input logic [31:0] start, input bit chain, input bit irqen);
        build_exp(start, chain);
        wr(A_MADDR, '0); wr(A_DADDR, '0); wr(A_COUNT, '0);
        wr(A_CSR, 32'h19);
        wr(A_MODE, {30'd0, irqen, chain});
        wr(A_DPTR, start);
        mv_idx = 0; n_fetch = 0;
        wr(A_CSR, 32'h03);
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        int t;
        for (t = 0; t < 5000; t++) begin
            @(negedge clk);
            rd(A_CSR, v);
            if (!v[5]) break;
        end
        chk(t < 5000, "R3 chain end timeout", 32'(t), 32'd5000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20417));
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk(v == '0, "R13 register after reset", v, '0);
        end
        chk(!irq && !fetch_req && !move_req, "R13 outputs idle after reset",
            {29'd0, irq, fetch_req, move_req}, '0);

        // R1 R2 R3 R6 R8 R10 R12: three-descriptor chain, middle one empty, stray bit 0 in links
        ack_pct = 60;
        put_desc(1, 32'h1000_0002, 32'h8000_0100, 32'd10, 32'h0000_0051);
        put_desc(5, 32'h2000_0000, 32'h8000_0200, 32'd0,  32'h0000_0090);
        put_desc(9, 32'h3000_0001, 32'h8000_0300, 32'd7,  32'h0000_0002);
        launch(32'h10, 1'b1, 1'b1);
        wait_idle();
        chk(mv_idx == exp_n, "R12 moves skip empty descriptor", 32'(mv_idx), 32'(exp_n));
        chk(n_fetch == 12, "R1 four words per descriptor", 32'(n_fetch), 32'd12);
        rd(A_CSR, v);
        chk(v[3] && v[4] && v[0], "R3 R6 done flags and enable", v, 32'h19);
        chk(irq == 1'b1, "R8 irq with enable and done", 32'(irq), 32'd1);
        rd(A_DPTR, v);
        chk(v == 32'h90, "R3 pointer holds last descriptor", v, 32'h90);
        rd(A_COUNT, v);
        chk(v == '0, "R10 count drained", v, '0);
        rd(A_MADDR, v);
        chk(v == 32'h3000_0008, "R10 mem address advanced", v, 32'h3000_0008);

        // R5 write-one-to-clear
        wr(A_CSR, 32'h09);
        rd(A_CSR, v);
        chk(!v[3] && v[4], "R5 xdone cleared, ddone kept", v, 32'h11);
        chk(irq == 1'b0, "R8 irq drops with xdone", 32'(irq), 32'd0);
        wr(A_CSR, 32'h01);
        rd(A_CSR, v);
        chk(v[4], "R5 writing zero keeps ddone", v, 32'h11);
        wr(A_CSR, 32'h11);
        rd(A_CSR, v);
        chk(!v[4], "R5 ddone cleared", v, 32'h01);

        // R4 R8 chain mode off, irq disabled
        put_desc(2, 32'h4000_0000, 32'h9000_0000, 32'd8, 32'h0000_0030);
        put_desc(3, 32'h5000_0000, 32'h9100_0000, 32'd8, 32'h0000_0002);
        launch(32'h20, 1'b0, 1'b0);
        wait_idle();
        chk(mv_idx == 2 && exp_n == 2, "R4 only first descriptor moved", 32'(mv_idx), 32'd2);
        chk(n_fetch == 4, "R4 only first descriptor fetched", 32'(n_fetch), 32'd4);
        rd(A_CSR, v);
        chk(v[3], "R4 xdone set", v, 32'h19);
        chk(irq == 1'b0, "R8 no irq when disabled", 32'(irq), 32'd0);
        rd(A_DPTR, v);
        chk(v == 32'h20, "R4 pointer on first descriptor", v, 32'h20);

        // R11 start with end-of-chain already in pointer
        launch(32'h42, 1'b1, 1'b1);
        rd(A_CSR, v);
        chk(v[3] && !v[5], "R11 immediate done", v, 32'h09);
        chk(n_fetch == 0 && !fetch_req, "R11 no fetch", 32'(n_fetch), 32'd0);

        // R9 start and register writes ignored while busy
        ack_pct = 30;
        put_desc(4, 32'h6000_0000, 32'hA000_0000, 32'd24, 32'h0000_0060);
        put_desc(6, 32'h7000_0000, 32'hA100_0000, 32'd20, 32'h0000_0003);
        launch(32'h40, 1'b1, 1'b0);
        for (int t = 0; t < 2000 && mv_idx < 2; t++) @(negedge clk);
        wr(A_CSR, 32'h03);
        wr(A_DPTR, 32'hA0);
        wr(A_COUNT, 32'd99);
        wait_idle();
        chk(mv_idx == exp_n, "R9 no restart, all moves once", 32'(mv_idx), 32'(exp_n));
        chk(n_fetch == 8, "R9 fetch count unchanged", 32'(n_fetch), 32'd8);
        rd(A_DPTR, v);
        chk(v == 32'h60, "R9 pointer write ignored", v, 32'h60);

        // R7 abort mid-transfer
        ack_pct = 50;
        put_desc(7, 32'h0800_0000, 32'hB000_0000, 32'd64, 32'h0000_0002);
        launch(32'h70, 1'b1, 1'b1);
        for (int t = 0; t < 2000 && mv_idx < 3; t++) @(negedge clk);
        hold = 1'b1;
        repeat (2) @(negedge clk);
        begin
            int snap;
            snap = mv_idx;
            wr(A_CSR, 32'h04);
            rd(A_CSR, v);
            chk(v[5:0] == 6'd0, "R7 abort clears enable, busy, no done", v, '0);
            chk(irq == 1'b0, "R7 no irq on abort", 32'(irq), 32'd0);
            hold = 1'b0;
            repeat (20) @(negedge clk);
            chk(mv_idx == snap && !fetch_req && !move_req, "R7 no moves after abort",
                32'(mv_idx), 32'(snap));
        end

        // random chains
        for (int r = 0; r < 25; r++) begin
            int nd, base;
            bit ch, ie;
            nd = 1 + ($urandom % 4);
            base = $urandom % 16;
            ch = ($urandom % 4) != 0;
            ie = $urandom % 2;
            ack_pct = 20 + ($urandom % 81);
            for (int k = 0; k < nd; k++) begin
                int s, sn;
                logic [31:0] lk;
                s  = (base + k * 5) % 16;
                sn = (base + (k + 1) * 5) % 16;
                lk = (k == nd - 1) ? (32'($urandom % 256) | 32'h2) : (32'(sn * 16) | 32'($urandom % 2));
                put_desc(s, $urandom, $urandom, 32'($urandom % 40), lk);
            end
            launch(32'(base * 16), ch, ie);
            wait_idle();
            chk(mv_idx == exp_n, "R2 random move count", 32'(mv_idx), 32'(exp_n));
            chk(n_fetch == 4 * exp_ndesc, "R3 random fetch count", 32'(n_fetch), 32'(4 * exp_ndesc));
            rd(A_CSR, v);
            chk(v[3] && v[4] == (exp_ndesc > 0), "R6 random done flags", v, 32'h19);
            chk(irq == ie, "R8 random irq", 32'(irq), 32'(ie));
            rd(A_COUNT, v);
            chk(v == '0, "R10 random count drained", v, '0);
            rd(A_DPTR, v);
            chk(v == exp_last, "R3 random last pointer", v, exp_last);
            rd(A_MADDR, v);
            chk(v == exp_mar, "R10 random mem address", v, exp_mar);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule